// File: doc/BRIEF.md
# Event Readout Integrity Checker

This block watches a stream of 32-bit readout words holding one event from several TDC boards, read one board after another, and decides whether the event is consistent and complete. Each board section is wrapped in a board header and board trailer. Inside it, per-chip sections are wrapped in a chip header and chip trailer, and a trigger time tag word follows them. The checker checks fields within each board and across all boards of the event. It matches event numbers, time tags and bunch ids, recounts the word totals, and checks which boards appear and in what order.

The word type is the code in bits 31:27. The stream is qualified by `in_valid`, and `in_last` marks the final word of an event. Two configuration inputs give the number of boards expected and their geographic addresses in the expected order. One cycle after the last word, the block reports a verdict: a done pulse, a pass flag and a 12-bit vector of error causes. It then starts the next event from a clean state.

Top module: `evr_integrity_chk`

## Requirements
- R1: The codes 01000 (board header), 00001 (chip header), 00000 (measurement), 00011 (chip trailer), 00100 (error packet), 10001 (time tag), 10000 (board trailer) and 11000 (filler) are accepted. Any other code in bits 31:27 sets error bit 0 (unknown type).
- R2: Error bit 1 (framing) is set by any of these: a non-filler word outside a board section; a second board header before a board trailer; a board trailer with no open board; a measurement outside a chip section; a chip header while a chip is open; a chip trailer with no open chip; a board boundary word while a chip is open; an event that ends with a board or a chip still open.
- R3: Error bit 2 (address) is set in two cases. The first is when the n-th board header's address (bits 4:0) differs from the n-th entry of `cfg_geo_order` (entry n in bits 5n+4:5n). The second is when a board trailer's address (bits 4:0) differs from its own header's address.
- R4: Error bit 3 (board count) is set when the number of board headers in the event differs from `cfg_boards`.
- R5: Error bit 4 (event number) is set when any board header's 22-bit event number (bits 26:5) differs from the first board header's event number in the event.
- R6: Error bit 5 (board word count) is set when a board trailer's count field (bits 20:5) differs from the number of non-filler words from that board's header through its trailer, both included.
- R7: Error bit 6 (status) is set when any board trailer has a nonzero value in bits 26:24.
- R8: Error bit 7 (time tag) is set when any time tag word's 27-bit value (bits 26:0) differs from the first time tag in the event.
- R9: Error bit 8 (chip event id) is set when a chip header's or chip trailer's event id (bits 23:12) differs from the low 12 bits of the event number of the enclosing board.
- R10: Error bit 9 (bunch) is set when a chip header's bunch id (bits 11:0) or a time tag's low 12 bits differ from the first of these values seen in the event.
- R11: Error bit 10 (chip word count) is set when a chip trailer's count field (bits 11:0) differs from the number of non-filler words from the chip header through the chip trailer, both included.
- R12: Error bit 11 (stray error packet) is set when the event holds an error packet and no board trailer in it has a status bit set.
- R13: Filler words and cycles with `in_valid` low change no count and no check result.
- R14: On the cycle after a valid word with `in_last` high, `evt_done` is high for one cycle. At the same time `evt_errs` shows the event's error bits and `evt_pass` is high exactly when none is set. Both hold until the next event ends and read 0 after reset. Every reference and count is cleared for the next event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word qualifier |
| in_data | input | 32 | Readout word |
| in_last | input | 1 | Final word of the event |
| cfg_boards | input | $clog2(MAX_BOARDS+1) | Number of boards expected per event |
| cfg_geo_order | input | 5*MAX_BOARDS | Expected board addresses, entry n in bits 5n+4:5n |
| evt_done | output | 1 | One-cycle pulse after each event |
| evt_pass | output | 1 | Event had no error |
| evt_errs | output | 12 | Error causes of the last event |

## Verification
The bench builds the block with MAX_BOARDS set to 4 and runs mostly with three boards configured. This keeps events short and still allows both a missing board and one board too many. One event raises `cfg_boards` to the full 4, so the last entry of the address list is reached. Event numbers are wider than 12 bits and time tags differ only above bit 11 in one event. These cases separate the full-width comparisons from the low-bit ones.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int GEO_W = 5;
  localparam int NERR  = 12;

  localparam int E_TYPE   = 0;
  localparam int E_FRAME  = 1;
  localparam int E_GEO    = 2;
  localparam int E_COUNT  = 3;
  localparam int E_EVNUM  = 4;
  localparam int E_BWC    = 5;
  localparam int E_STAT   = 6;
  localparam int E_TTAG   = 7;
  localparam int E_CHIPID = 8;
  localparam int E_BUNCH  = 9;
  localparam int E_CWC    = 10;
  localparam int E_ERRPKT = 11;

  typedef enum logic [4:0] {
    PK_BHDR = 5'b01000,
    PK_CHDR = 5'b00001,
    PK_MEAS = 5'b00000,
    PK_CTRL = 5'b00011,
    PK_EPKT = 5'b00100,
    PK_TTAG = 5'b10001,
    PK_BTRL = 5'b10000,
    PK_FILL = 5'b11000
  } pk_code_e;

  typedef struct packed {
    logic bhdr;
    logic chdr;
    logic meas;
    logic ctrl;
    logic epkt;
    logic ttag;
    logic btrl;
    logic fill;
    logic bad;
  } pk_class_t;

  function automatic pk_class_t classify(logic [4:0] code);
    pk_class_t c;
    c = '0;
    case (code)
      PK_BHDR: c.bhdr = 1'b1;
      PK_CHDR: c.chdr = 1'b1;
      PK_MEAS: c.meas = 1'b1;
      PK_CTRL: c.ctrl = 1'b1;
      PK_EPKT: c.epkt = 1'b1;
      PK_TTAG: c.ttag = 1'b1;
      PK_BTRL: c.btrl = 1'b1;
      PK_FILL: c.fill = 1'b1;
      default: c.bad  = 1'b1;
    endcase
    return c;
  endfunction

  // payload is bits 26:0 of a readout word
  function automatic logic [GEO_W-1:0] f_geo(logic [26:0] p);
    return p[4:0];
  endfunction
  function automatic logic [21:0] f_evnum(logic [26:0] p);
    return p[26:5];
  endfunction
  function automatic logic [15:0] f_bwc(logic [26:0] p);
    return p[20:5];
  endfunction
  function automatic logic [2:0] f_stat(logic [26:0] p);
    return p[26:24];
  endfunction
  function automatic logic [11:0] f_evid(logic [26:0] p);
    return p[23:12];
  endfunction
  function automatic logic [11:0] f_low12(logic [26:0] p);
    return p[11:0];
  endfunction
endpackage

// File: rtl/evr_decode.sv
module evr_decode
  import evr_pkg::*;
(
  input  logic       vld,
  input  logic [4:0] code,
  output pk_class_t  cls
);
  always_comb begin
    cls = vld ? classify(code) : '0;
  end
endmodule

// File: rtl/evr_board_chk.sv
module evr_board_chk
  import evr_pkg::*;
#(
  parameter int MAX_BOARDS = 8,
  localparam int CNT_W = $clog2(MAX_BOARDS + 1),
  localparam int IDX_W = $clog2(MAX_BOARDS + 2)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        word_v,
  input  logic                        evt_end,
  input  logic                        is_bhdr,
  input  logic                        is_btrl,
  input  logic                        is_fill,
  input  logic [26:0]                 pay,
  input  logic [CNT_W-1:0]            cfg_boards,
  input  logic [MAX_BOARDS*GEO_W-1:0] cfg_geo_order,
  output logic [NERR-1:0]             err_acc,
  output logic [11:0]                 cur_evnum12
);
  logic             open_q, open_n;
  logic [GEO_W-1:0] geo_q, geo_n;
  logic [15:0]      cnt_q, cnt_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [21:0]      eref_q, eref_n;
  logic             eref_v_q, eref_v_n;
  logic [11:0]      ecur_q, ecur_n;
  logic [NERR-1:0]  sticky_q;
  logic [NERR-1:0]  e;
  logic [GEO_W-1:0] exp_geo;

  always_comb begin
    exp_geo = '0;
    for (int i = 0; i < MAX_BOARDS; i++) begin
      if (idx_q == IDX_W'(i)) exp_geo = cfg_geo_order[i*GEO_W +: GEO_W];
    end
  end

  always_comb begin
    e        = '0;
    open_n   = open_q;
    geo_n    = geo_q;
    cnt_n    = cnt_q;
    idx_n    = idx_q;
    eref_n   = eref_q;
    eref_v_n = eref_v_q;
    ecur_n   = ecur_q;
    if (word_v && !is_fill) begin
      if (is_bhdr) begin
        if (open_q) e[E_FRAME] = 1'b1;
        open_n = 1'b1;
        cnt_n  = 16'd1;
        geo_n  = f_geo(pay);
        ecur_n = f_evnum(pay)[11:0];
        if (idx_q >= IDX_W'(cfg_boards)) e[E_COUNT] = 1'b1;
        else if (f_geo(pay) != exp_geo)  e[E_GEO]   = 1'b1;
        if (idx_q < IDX_W'(MAX_BOARDS + 1)) idx_n = idx_q + 1'b1;
        if (eref_v_q) begin
          if (f_evnum(pay) != eref_q) e[E_EVNUM] = 1'b1;
        end else begin
          eref_n   = f_evnum(pay);
          eref_v_n = 1'b1;
        end
      end else if (!open_q) begin
        e[E_FRAME] = 1'b1;
      end else if (is_btrl) begin
        open_n = 1'b0;
        if (f_geo(pay) != geo_q)         e[E_GEO]  = 1'b1;
        if (f_bwc(pay) != cnt_q + 16'd1) e[E_BWC]  = 1'b1;
        if (f_stat(pay) != 3'd0)         e[E_STAT] = 1'b1;
      end else begin
        cnt_n = cnt_q + 16'd1;
      end
    end
    if (evt_end) begin
      if (open_n) e[E_FRAME] = 1'b1;
      if (idx_n != IDX_W'(cfg_boards)) e[E_COUNT] = 1'b1;
    end
    err_acc = sticky_q | e;
  end

  assign cur_evnum12 = ecur_q;

  always_ff @(posedge clk) begin
    if (!rst_n || evt_end) begin
      open_q   <= 1'b0;
      geo_q    <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      eref_q   <= '0;
      eref_v_q <= 1'b0;
      ecur_q   <= '0;
      sticky_q <= '0;
    end else begin
      open_q   <= open_n;
      geo_q    <= geo_n;
      cnt_q    <= cnt_n;
      idx_q    <= idx_n;
      eref_q   <= eref_n;
      eref_v_q <= eref_v_n;
      ecur_q   <= ecur_n;
      sticky_q <= sticky_q | e;
    end
  end
endmodule

// File: rtl/evr_chip_chk.sv
module evr_chip_chk
  import evr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_end,
  input  pk_class_t       cls,
  input  logic [26:0]     pay,
  input  logic [11:0]     brd_evnum12,
  output logic [NERR-1:0] err_acc,
  output logic            epkt_acc
);
  logic            copen_q, copen_n;
  logic [11:0]     ccnt_q, ccnt_n;
  logic [11:0]     bref_q, bref_n;
  logic            bref_v_q, bref_v_n;
  logic [26:0]     tref_q, tref_n;
  logic            tref_v_q, tref_v_n;
  logic            epkt_q;
  logic [NERR-1:0] sticky_q;
  logic [NERR-1:0] e;

  always_comb begin
    e        = '0;
    copen_n  = copen_q;
    ccnt_n   = ccnt_q;
    bref_n   = bref_q;
    bref_v_n = bref_v_q;
    tref_n   = tref_q;
    tref_v_n = tref_v_q;
    if (cls.bad) e[E_TYPE] = 1'b1;
    if (cls.chdr) begin
      if (copen_q) e[E_FRAME] = 1'b1;
      copen_n = 1'b1;
      ccnt_n  = 12'd1;
      if (f_evid(pay) != brd_evnum12) e[E_CHIPID] = 1'b1;
      if (bref_v_q) begin
        if (f_low12(pay) != bref_q) e[E_BUNCH] = 1'b1;
      end else begin
        bref_n   = f_low12(pay);
        bref_v_n = 1'b1;
      end
    end else if (cls.ctrl) begin
      if (!copen_q) begin
        e[E_FRAME] = 1'b1;
      end else begin
        copen_n = 1'b0;
        if (f_low12(pay) != ccnt_q + 12'd1) e[E_CWC] = 1'b1;
      end
      if (f_evid(pay) != brd_evnum12) e[E_CHIPID] = 1'b1;
    end else if (cls.bhdr || cls.btrl) begin
      if (copen_q) begin
        e[E_FRAME] = 1'b1;
        copen_n    = 1'b0;
      end
    end else if (!cls.fill && (cls.meas || cls.epkt || cls.ttag || cls.bad)) begin
      if (copen_q) ccnt_n = ccnt_q + 12'd1;
      else if (cls.meas) e[E_FRAME] = 1'b1;
      if (cls.ttag) begin
        if (tref_v_q) begin
          if (pay != tref_q) e[E_TTAG] = 1'b1;
        end else begin
          tref_n   = pay;
          tref_v_n = 1'b1;
        end
        if (bref_v_q) begin
          if (f_low12(pay) != bref_q) e[E_BUNCH] = 1'b1;
        end else begin
          bref_n   = f_low12(pay);
          bref_v_n = 1'b1;
        end
      end
    end
    if (evt_end && copen_n) e[E_FRAME] = 1'b1;
    err_acc  = sticky_q | e;
    epkt_acc = epkt_q | cls.epkt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || evt_end) begin
      copen_q  <= 1'b0;
      ccnt_q   <= '0;
      bref_q   <= '0;
      bref_v_q <= 1'b0;
      tref_q   <= '0;
      tref_v_q <= 1'b0;
      epkt_q   <= 1'b0;
      sticky_q <= '0;
    end else begin
      copen_q  <= copen_n;
      ccnt_q   <= ccnt_n;
      bref_q   <= bref_n;
      bref_v_q <= bref_v_n;
      tref_q   <= tref_n;
      tref_v_q <= tref_v_n;
      epkt_q   <= epkt_acc;
      sticky_q <= sticky_q | e;
    end
  end
endmodule

// File: rtl/evr_integrity_chk.sv
module evr_integrity_chk
  import evr_pkg::*;
#(
  parameter int MAX_BOARDS = 8,
  localparam int CNT_W = $clog2(MAX_BOARDS + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [31:0]                 in_data,
  input  logic                        in_last,
  input  logic [CNT_W-1:0]            cfg_boards,
  input  logic [MAX_BOARDS*GEO_W-1:0] cfg_geo_order,
  output logic                        evt_done,
  output logic                        evt_pass,
  output logic [NERR-1:0]             evt_errs
);
  pk_class_t       cls;
  logic            evt_end;
  logic [NERR-1:0] brd_err;
  logic [NERR-1:0] chp_err;
  logic            chp_epkt;
  logic [11:0]     brd_evnum12;
  logic [NERR-1:0] errs_now;

  assign evt_end = in_valid && in_last;

  evr_decode u_dec (
    .vld  (in_valid),
    .code (in_data[31:27]),
    .cls  (cls)
  );

  evr_board_chk #(.MAX_BOARDS(MAX_BOARDS)) u_brd (
    .clk           (clk),
    .rst_n         (rst_n),
    .word_v        (in_valid),
    .evt_end       (evt_end),
    .is_bhdr       (cls.bhdr),
    .is_btrl       (cls.btrl),
    .is_fill       (cls.fill),
    .pay           (in_data[26:0]),
    .cfg_boards    (cfg_boards),
    .cfg_geo_order (cfg_geo_order),
    .err_acc       (brd_err),
    .cur_evnum12   (brd_evnum12)
  );

  evr_chip_chk u_chp (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_end     (evt_end),
    .cls         (cls),
    .pay         (in_data[26:0]),
    .brd_evnum12 (brd_evnum12),
    .err_acc     (chp_err),
    .epkt_acc    (chp_epkt)
  );

  always_comb begin
    errs_now = brd_err | chp_err;
    errs_now[E_ERRPKT] = chp_epkt && !brd_err[E_STAT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_done <= 1'b0;
      evt_pass <= 1'b0;
      evt_errs <= '0;
    end else begin
      evt_done <= evt_end;
      if (evt_end) begin
        evt_errs <= errs_now;
        evt_pass <= ~|errs_now;
      end
    end
  end
endmodule

// File: rtl/evr_integrity_sva.sv
module evr_integrity_sva
  import evr_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_last,
  input logic [31:0]     in_data,
  input logic            evt_end,
  input logic            evt_done,
  input logic            evt_pass,
  input logic [NERR-1:0] evt_errs
);
  a_r14_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    evt_end |=> evt_done);

  a_r14_done_needs_last: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> $past(in_valid && in_last));

  a_r14_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_end |=> ($stable(evt_errs) && $stable(evt_pass)));

  a_r14_fail_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done && !evt_pass) |-> (evt_errs != '0));

  a_r7_status_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && in_data[31:27] == 5'b10000 && in_data[26:24] != 3'd0)
      |=> evt_errs[E_STAT]);

  a_r1_type_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && !(in_data[31:27] inside {5'b01000, 5'b00001, 5'b00000,
      5'b00011, 5'b00100, 5'b10001, 5'b10000, 5'b11000})) |=> evt_errs[E_TYPE]);
endmodule

bind evr_integrity_chk evr_integrity_sva u_sva (.*);

// File: tb/evr_integrity_chk_tb.sv
module evr_integrity_chk_tb;
  localparam int MB = 4;
  localparam int CW = $clog2(MB + 1);

  localparam logic [11:0] X_NONE = 12'h000;
  localparam logic [11:0] X_TYPE = 12'h001, X_FRAME = 12'h002, X_GEO = 12'h004;
  localparam logic [11:0] X_CNT = 12'h008, X_EVN = 12'h010, X_BWC = 12'h020;
  localparam logic [11:0] X_STAT = 12'h040, X_TTAG = 12'h080, X_CID = 12'h100;
  localparam logic [11:0] X_BUN = 12'h200, X_CWC = 12'h400, X_EPK = 12'h800;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_data = '0;
  logic [CW-1:0] cfg_boards = CW'(3);
  logic [MB*5-1:0] cfg_geo_order = {5'd19, 5'd5, 5'd2, 5'd7};
  logic evt_done, evt_pass;
  logic [11:0] evt_errs;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [31:0] ev[$];
  logic [11:0] exp_q[$];
  string tag_q[$];
  int cur_evn = 32'h12345;
  int cur_tt = 32'h0ABCDEF;
  int geos[4] = '{7, 2, 5, 19};

  always #10 clk = ~clk;

  evr_integrity_chk #(.MAX_BOARDS(MB)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .cfg_boards(cfg_boards), .cfg_geo_order(cfg_geo_order),
    .evt_done(evt_done), .evt_pass(evt_pass), .evt_errs(evt_errs));

  typedef struct {
    int geo; int evnum; int ttag; int nhits; int stat;
    bit epkt; bit fill; bit badtype;
    int wc_d; int cwc_d; int evid_d; int bunch_d; int tgeo_d;
  } bopt_t;

  function automatic bopt_t dflt(int b);
    bopt_t o;
    o = '{geo: geos[b], evnum: cur_evn, ttag: cur_tt, nhits: b + 1, stat: 0,
          epkt: 1'b0, fill: 1'b0, badtype: 1'b0, wc_d: 0, cwc_d: 0,
          evid_d: 0, bunch_d: 0, tgeo_d: 0};
    return o;
  endfunction

  function automatic void add_board(bopt_t o);
    int bwc;
    logic [21:0] en;
    logic [4:0] g;
    en = o.evnum[21:0];
    g = o.geo[4:0];
    ev.push_back({5'b01000, en, g});
    bwc = 1;
    if (o.fill) ev.push_back({5'b11000, 27'h0});
    for (int c = 0; c < 2; c++) begin
      logic [11:0] id, bn, cw;
      id = 12'(o.evnum + ((c == 0) ? o.evid_d : 0));
      bn = 12'(o.ttag + ((c == 0) ? o.bunch_d : 0));
      cw = 12'(2 + o.nhits);
      ev.push_back({5'b00001, 1'b0, 2'(c), id, bn});
      if (o.fill && c == 0) ev.push_back({5'b11000, 27'h0});
      for (int h = 0; h < o.nhits; h++) begin
        if (o.badtype && c == 0 && h == 0) ev.push_back({5'b01111, 27'h3});
        else ev.push_back({5'b00000, 27'(h + 16)});
      end
      if (o.epkt && c == 0) begin
        ev.push_back({5'b00100, 27'h5});
        cw = cw + 12'd1;
      end
      bwc = bwc + int'(cw);
      if (c == 0) cw = 12'(int'(cw) + o.cwc_d);
      ev.push_back({5'b00011, 1'b0, 2'(c), id, cw});
    end
    ev.push_back({5'b10001, 27'(o.ttag)});
    bwc = bwc + 2;
    ev.push_back({5'b10000, 3'(o.stat), 3'b000, 16'(bwc + o.wc_d), 5'(o.geo + o.tgeo_d)});
  endfunction

  function automatic void std_boards(int n);
    for (int b = 0; b < n; b++) add_board(dflt(b));
  endfunction

  function automatic void next_ids();
    cur_evn = cur_evn + 32'h1001;
    cur_tt = cur_tt + 32'h203;
  endfunction

  task automatic send_event(logic [11:0] exp, string tag, bit gaps);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    for (int i = 0; i < ev.size(); i++) begin
      if (gaps && (i % 2 == 1)) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data = 32'hDEAD_BEEF;
        in_last = 1'b1;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_data = ev[i];
      in_last = (i == ev.size() - 1);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last = 1'b0;
    ev.delete();
    next_ids();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a verdict appears
  always @(negedge clk) begin
    if (rst_n && evt_done) begin
      if (exp_q.size() == 0) begin
        chk("R14 unexpected done", 32'(evt_errs), 32'hFFFF_FFFF);
      end else begin
        logic [11:0] x;
        string t;
        x = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " errs"}, 32'(evt_errs), 32'(x));
        chk({t, " R14 pass"}, 32'(evt_pass), 32'(x == 12'h000));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    bopt_t o;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R14 reset done", 32'(evt_done), 0);
    chk("R14 reset pass", 32'(evt_pass), 0);
    chk("R14 reset errs", 32'(evt_errs), 0);

    std_boards(3);                       send_event(X_NONE, "R14 clean", 1'b0);
    for (int b = 0; b < 3; b++) begin o = dflt(b); o.fill = 1'b1; add_board(o);
      ev.push_back({5'b11000, 27'h0}); end
    send_event(X_NONE, "R13 fillers and gaps", 1'b1);

    o = dflt(0); o.badtype = 1'b1; add_board(o); add_board(dflt(1)); add_board(dflt(2));
    send_event(X_TYPE, "R1 unknown code", 1'b0);

    add_board(dflt(1)); add_board(dflt(0)); add_board(dflt(2));
    send_event(X_GEO, "R3 swapped order", 1'b0);

    add_board(dflt(0)); o = dflt(1); o.tgeo_d = 1; add_board(o); add_board(dflt(2));
    send_event(X_GEO, "R3 trailer address", 1'b0);

    std_boards(2);                       send_event(X_CNT, "R4 missing board", 1'b0);
    std_boards(4);                       send_event(X_CNT, "R4 extra board", 1'b0);

    cfg_boards = CW'(4);
    std_boards(4);                       send_event(X_NONE, "R3 R4 full list", 1'b0);
    cfg_boards = CW'(3);

    add_board(dflt(0)); o = dflt(1); o.evnum = cur_evn + 32'h1000; add_board(o);
    add_board(dflt(2));                  send_event(X_EVN, "R5 event number", 1'b0);

    add_board(dflt(0)); add_board(dflt(1)); o = dflt(2); o.wc_d = -1; add_board(o);
    send_event(X_BWC, "R6 board count", 1'b0);

    o = dflt(0); o.stat = 2; o.epkt = 1'b1; add_board(o); std_boards(0);
    add_board(dflt(1)); add_board(dflt(2));
    send_event(X_STAT, "R7 status with packet", 1'b0);

    o = dflt(0); o.stat = 4; add_board(o); add_board(dflt(1)); add_board(dflt(2));
    ev[ev.size()-1] = ev[ev.size()-1];
    send_event(X_STAT, "R7 status", 1'b0);

    add_board(dflt(0)); add_board(dflt(1)); o = dflt(2); o.ttag = cur_tt + 32'h1000;
    add_board(o);                        send_event(X_TTAG, "R8 time tag", 1'b0);

    o = dflt(0); o.evid_d = 1; add_board(o); add_board(dflt(1)); add_board(dflt(2));
    send_event(X_CID, "R9 chip event id", 1'b0);

    add_board(dflt(0)); o = dflt(1); o.bunch_d = 3; add_board(o); add_board(dflt(2));
    send_event(X_BUN, "R10 bunch id", 1'b0);

    add_board(dflt(0)); o = dflt(1); o.cwc_d = 2; add_board(o); add_board(dflt(2));
    send_event(X_CWC, "R11 chip count", 1'b0);

    add_board(dflt(0)); o = dflt(1); o.epkt = 1'b1; add_board(o); add_board(dflt(2));
    send_event(X_EPK, "R12 stray error packet", 1'b0);

    ev.push_back({5'b00000, 27'h9}); std_boards(3);
    send_event(X_FRAME, "R2 word outside board", 1'b0);

    std_boards(2);
    ev.push_back({5'b01000, 22'(cur_evn), 5'd5});
    ev.push_back({5'b00001, 3'b000, 12'(cur_evn), 12'(cur_tt)});
    ev.push_back({5'b00000, 27'h1});
    send_event(X_FRAME, "R2 truncated event", 1'b0);

    std_boards(3);                       send_event(X_NONE, "R14 clean after errors", 1'b0);

    repeat (5) @(negedge clk);
    chk("R14 scoreboard drained", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule